// File: doc/BRIEF.md
# Status register and write-protect unit for a serial memory

This unit keeps the control state that guards a small serial nonvolatile memory. It holds the write-enable flag, two region-protect bits, a pin-lock enable bit and the busy indication. It decides whether the write instruction the command engine has just finished may start a programming cycle. It then times that cycle in system clocks. The command engine sends it single-cycle strobes: set or clear write enable, begin a write instruction (array or status, with its target address) and end the instruction when chip select rises.

The unit returns the status byte that a read-status instruction shifts out, a busy flag, a one-cycle pulse when a programming cycle starts, and a combinational permit for the array address currently presented. The protect bits stand in for nonvolatile cells. An asynchronous hard reset clears them. A synchronous soft reset, which models a power cycle, leaves them as they were and clears only the volatile state.

Top module: `wp_status_unit`

## Requirements
- R1: While idle, the status byte is {WPEN, 3'b000, BP[1], BP[0], WEN, 1'b0}, so bit 7 is WPEN, bits 3:2 are BP, bit 1 is WEN and bit 0 is 0 (ready).
- R2: An accepted write keeps `busy` high for exactly WR_CYCLES clocks, starting the clock after the end strobe, and the status byte reads 8'hFF throughout.
- R3: The protected array region counts down from the top address. BP=2'b00 protects nothing. 2'b01 protects the addresses whose two MSBs are 2'b11. 2'b10 protects the addresses with MSB 1. 2'b11 protects every address. `arr_permit` is high only for an unprotected address while WEN=1 and the unit is idle.
- R4: A write instruction that ends while WEN=0 starts no cycle.
- R5: WEN reads 0 after the end of every write instruction, including one that was refused.
- R6: When WPEN=1 and `wp_n` is low, a status write is refused. An array write to an unprotected address is still accepted.
- R7: A falling edge on `wp_n` between begin and end cancels that instruction. A fall after the cycle has started does not stop it, and the new status value still lands.
- R8: The clear-enable strobe drops WEN whatever the level of `wp_n`.
- R9: Soft reset clears WEN and keeps BP and WPEN. Hard reset clears all status bits.
- R10: While busy, the set-enable, clear-enable and begin strobes are ignored.
- R11: `cycle_go` pulses for one clock, in the first busy clock of each accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset (power-cycle model) |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| op_wen_set | input | 1 | Set-write-enable strobe |
| op_wen_clr | input | 1 | Clear-write-enable strobe |
| op_wr_begin | input | 1 | Write instruction has its opcode and address |
| op_wr_is_status | input | 1 | With begin: 1 for a status write, 0 for an array write |
| op_addr | input | ADDR_W | Target address; also the address that `arr_permit` judges |
| op_status_din | input | 8 | New status value, sampled at the end strobe |
| op_wr_end | input | 1 | Chip select rose, which ends the instruction |
| status_q | output | 8 | Status byte for read-status |
| busy | output | 1 | Programming cycle in progress |
| arr_permit | output | 1 | Array write to `op_addr` would be accepted now |
| cycle_go | output | 1 | One-clock pulse at the start of a cycle |

## Verification
The assertions assume the command engine sends each strobe for one clock only. They also assume it never sends an end strobe in the same clock as a begin or an enable strobe, and never sends a begin while a write instruction is already open. The bench drives every strobe through tasks that raise it for a single clock and run the steps of an instruction in order. It moves `wp_n` only between strobes, so each protection case is set up before the strobe that tests it.

// File: rtl/wpsu_pkg.sv
package wpsu_pkg;

  // Region lock: top quarter, top half or everything, chosen by the protect code
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic wpen, input logic [1:0] bp,
                                             input logic wen, input logic busy);
    if (busy) return 8'hFF;
    return {wpen, 3'b000, bp, wen, 1'b0};
  endfunction

endpackage

// File: rtl/wpsu_guard.sv
module wpsu_guard #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  import wpsu_pkg::*;
  localparam int MSB = ADDR_W - 1;

  always_comb locked = region_locked(bp, addr[MSB -: 2]);
endmodule

// File: rtl/wpsu_timer.sv
module wpsu_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (load)      cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit #(
  parameter int ADDR_W    = 11,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wp_n,
  input  logic              op_wen_set,
  input  logic              op_wen_clr,
  input  logic              op_wr_begin,
  input  logic              op_wr_is_status,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_status_din,
  input  logic              op_wr_end,
  output logic [7:0]        status_q,
  output logic              busy,
  output logic              arr_permit,
  output logic              cycle_go
);
  import wpsu_pkg::*;

  logic              wen_q, wpen_q, wp_q, go_q;
  logic [1:0]        bp_q;
  logic              pend_q, pend_status_q, cancel_q;
  logic [ADDR_W-1:0] addr_q;

  // named internal events
  logic w_take, w_wp_fall, w_hw_lock, w_lock_req, w_lock_now;
  logic w_allowed, w_finish, w_accept;

  wpsu_guard #(.ADDR_W(ADDR_W)) u_guard_req (.bp(bp_q), .addr(addr_q),  .locked(w_lock_req));
  wpsu_guard #(.ADDR_W(ADDR_W)) u_guard_now (.bp(bp_q), .addr(op_addr), .locked(w_lock_now));

  wpsu_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .load(w_accept), .busy(busy)
  );

  assign w_take    = ~busy & ~soft_rst;
  assign w_wp_fall = wp_q & ~wp_n;
  assign w_hw_lock = wpen_q & ~wp_n;
  assign w_allowed = pend_status_q ? (wen_q & ~w_hw_lock) : (wen_q & ~w_lock_req);
  assign w_finish  = op_wr_end & pend_q & ~soft_rst;
  assign w_accept  = w_finish & w_allowed & ~cancel_q & ~w_wp_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wen_q <= 1'b0;
    else if (soft_rst)                wen_q <= 1'b0;
    else if (w_finish)                wen_q <= 1'b0;
    else if (w_take && op_wen_clr)    wen_q <= 1'b0;
    else if (w_take && op_wen_set)    wen_q <= 1'b1;
  end

  // protect bits survive soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= 2'b00;
      wpen_q <= 1'b0;
    end else if (w_accept && pend_status_q) begin
      bp_q   <= op_status_din[3:2];
      wpen_q <= op_status_din[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q        <= 1'b0;
      pend_status_q <= 1'b0;
      cancel_q      <= 1'b0;
      addr_q        <= '0;
    end else if (soft_rst || w_finish) begin
      pend_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else if (w_take && op_wr_begin) begin
      pend_q        <= 1'b1;
      pend_status_q <= op_wr_is_status;
      cancel_q      <= 1'b0;
      addr_q        <= op_addr;
    end else if (pend_q && w_wp_fall) begin
      cancel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= 1'b1;
      go_q <= 1'b0;
    end else begin
      wp_q <= wp_n;
      go_q <= w_accept;
    end
  end

  assign status_q   = pack_status(wpen_q, bp_q, wen_q, busy);
  assign arr_permit = wen_q & ~busy & ~w_lock_now;
  assign cycle_go   = go_q;
endmodule

// File: rtl/wp_status_unit_chk.sv
module wp_status_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wp_n,
  input logic       op_wr_end,
  input logic [7:0] status_q,
  input logic       busy,
  input logic       cycle_go,
  input logic       wen_q,
  input logic       wpen_q,
  input logic       pend_q,
  input logic       pend_status_q
);
  a_r2_busy_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_q == 8'hFF);

  a_r1_idle_layout: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_q[6:4] == 3'b000 && !status_q[0] && status_q[1] == wen_q));

  a_r5_wen_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_end && pend_q) |=> !wen_q);

  a_r10_busy_freezes_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst) |=> $stable(wen_q));

  a_r11_go_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_go |-> busy);

  a_r6_status_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_end && pend_q && pend_status_q && wpen_q && !wp_n) |=> !cycle_go);

  a_r4_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr_end && !wen_q) |=> !cycle_go);

  a_r9_soft_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!wen_q && $stable(wpen_q)));
endmodule

bind wp_status_unit wp_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wp_n(wp_n),
  .op_wr_end(op_wr_end), .status_q(status_q), .busy(busy), .cycle_go(cycle_go),
  .wen_q(wen_q), .wpen_q(wpen_q), .pend_q(pend_q), .pend_status_q(pend_status_q)
);

// File: tb/test_wp_status_unit.sv
module test_wp_status_unit;
  localparam int AW = 11;
  localparam int WR = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, wp_n = 1'b1;
  logic op_wen_set = 1'b0, op_wen_clr = 1'b0, op_wr_begin = 1'b0, op_wr_is_status = 1'b0;
  logic op_wr_end = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0] op_status_din = 8'h00;
  logic [7:0] status_q;
  logic busy, arr_permit, cycle_go;

  always #4 clk = ~clk;

  wp_status_unit #(.ADDR_W(AW), .WR_CYCLES(WR)) i_wp_status_unit (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wp_n(wp_n),
    .op_wen_set(op_wen_set), .op_wen_clr(op_wen_clr), .op_wr_begin(op_wr_begin),
    .op_wr_is_status(op_wr_is_status), .op_addr(op_addr), .op_status_din(op_status_din),
    .op_wr_end(op_wr_end), .status_q(status_q), .busy(busy),
    .arr_permit(arr_permit), .cycle_go(cycle_go)
  );

  typedef struct {int field; logic [7:0] val; string req;} item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.field)
        0:       act = status_q;
        1:       act = {7'd0, busy};
        2:       act = {7'd0, arr_permit};
        default: act = {7'd0, cycle_go};
      endcase
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s field %0d actual %h expected %h", it.req, it.field, act, it.val);
      end
    end
  end

  task automatic expect_item(input int f, input logic [7:0] v, input string r);
    item_t it;
    it.field = f; it.val = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic wen_set(); op_wen_set = 1; tick(); op_wen_set = 0; endtask
  task automatic wen_clr(); op_wen_clr = 1; tick(); op_wen_clr = 0; endtask
  task automatic settle(); repeat (WR + 1) tick(); endtask

  // full write instruction; after return the start clock is visible
  task automatic wr_instr(input bit is_st, input logic [AW-1:0] a, input logic [7:0] d,
                          input bit drop_wp);
    op_wr_is_status = is_st; op_addr = a; op_status_din = d;
    op_wr_begin = 1; tick(); op_wr_begin = 0;
    tick();
    if (drop_wp) begin wp_n = 0; tick(); end
    op_wr_end = 1; tick(); op_wr_end = 0;
  endtask

  function automatic logic [7:0] st(input logic wpen, input logic [1:0] bp, input logic wen);
    return {wpen, 3'b000, bp, wen, 1'b0};
  endfunction

  // independent restatement of region protection by address thresholds
  function automatic logic prot(input logic [1:0] bp, input int a);
    int lo;
    lo = (bp == 2'b00) ? DEPTH : (bp == 2'b01) ? (3 * DEPTH / 4) :
         (bp == 2'b10) ? (DEPTH / 2) : 0;
    return a >= lo;
  endfunction

  task automatic permit_at(input int a, input logic [1:0] bp, input logic wen, input string r);
    op_addr = AW'(a); #1;
    expect_item(2, {7'd0, wen & ~prot(bp, a)}, r);
    tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    expect_item(0, 8'h00, "R9 hard reset status");
    expect_item(1, 8'h00, "R9 idle after reset");
    tick();
    wen_set();
    expect_item(0, st(0, 2'b00, 1), "R1 wen bit 1");
    // array write accepted, cycle timing
    wr_instr(0, 11'h000, 8'h00, 0);
    expect_item(3, 8'h01, "R11 go pulse");
    expect_item(0, 8'hFF, "R2 busy reads ones");
    tick();
    expect_item(3, 8'h00, "R11 go one clock");
    op_wen_set = 1; tick(); op_wen_set = 0;   // R10 ignored while busy
    repeat (WR - 3) tick();
    expect_item(1, 8'h01, "R2 busy last clock");
    tick();
    expect_item(1, 8'h00, "R2 busy length");
    expect_item(0, st(0, 2'b00, 0), "R5 R10 wen clear after cycle");
    tick();
    // status write wpen=1 bp=11
    wen_set();
    wr_instr(1, '0, 8'h8C, 0);
    settle();
    expect_item(0, st(1, 2'b11, 0), "R1 status layout after write");
    tick();
    // R6 locked status write
    wp_n = 0; tick();
    wen_set();
    wr_instr(1, '0, 8'h04, 0);
    expect_item(3, 8'h00, "R6 status write refused");
    expect_item(0, st(1, 2'b11, 0), "R6 R5 status unchanged wen dropped");
    tick();
    wp_n = 1; tick();
    wen_set();
    wr_instr(1, '0, 8'h84, 0);
    settle();
    expect_item(0, st(1, 2'b01, 0), "R1 bp01");
    tick();
    wp_n = 0; tick();
    wen_set();
    permit_at(0,     2'b01, 1, "R3 quarter low");
    permit_at(12'h600, 2'b01, 1, "R3 quarter top");
    permit_at(12'h5FF, 2'b01, 1, "R3 quarter edge");
    wr_instr(0, 11'h100, 8'h00, 0);
    expect_item(3, 8'h01, "R6 array write under pin lock");
    settle();
    wen_set();
    wr_instr(0, 11'h7FF, 8'h00, 0);
    expect_item(3, 8'h00, "R3 protected write refused");
    expect_item(0, st(1, 2'b01, 0), "R5 wen clear on refused");
    tick();
    // R7 cancel by wp fall
    wp_n = 1; tick();
    wen_set();
    wr_instr(0, 11'h010, 8'h00, 1);
    expect_item(3, 8'h00, "R7 wp fall cancels");
    expect_item(0, st(1, 2'b01, 0), "R7 R5 wen clear after cancel");
    tick();
    wp_n = 1; tick();
    wen_set();
    wr_instr(1, '0, 8'h08, 0);
    expect_item(3, 8'h01, "R7 status cycle starts");
    wp_n = 0; tick();
    expect_item(1, 8'h01, "R7 wp fall in cycle keeps busy");
    settle();
    expect_item(0, st(0, 2'b10, 0), "R7 status lands");
    tick();
    wen_set();
    permit_at(12'h3FF, 2'b10, 1, "R3 half low");
    permit_at(12'h400, 2'b10, 1, "R3 half top");
    wen_clr();
    expect_item(0, st(0, 2'b10, 0), "R8 clear with wp low");
    tick();
    // R9 soft reset
    wen_set();
    expect_item(0, st(0, 2'b10, 1), "R9 wen set before soft");
    soft_rst = 1; tick(); soft_rst = 0;
    expect_item(0, st(0, 2'b10, 0), "R9 soft keeps bp");
    tick();
    rst_n = 0; tick(); rst_n = 1; tick();
    expect_item(0, 8'h00, "R9 hard clears bp");
    tick();
    wp_n = 1;
    wen_set();
    permit_at(12'h7FF, 2'b00, 1, "R3 none protected");
    wen_clr();
    permit_at(12'h000, 2'b00, 0, "R4 permit needs wen");
    wr_instr(0, 11'h000, 8'h00, 0);
    expect_item(3, 8'h00, "R4 no cycle without wen");
    expect_item(1, 8'h00, "R4 stays idle");
    repeat (3) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule